// File: doc/BRIEF.md
# UART Transmit Byte Queue with Threshold Events

This block holds bytes waiting to be sent by a UART serializer. Bytes arrive through a one-cycle write strobe with an 8-bit data word. They leave through a ready/valid port toward the serializer, oldest first. The block tracks how many bytes it holds and drives full and empty flags from that count. It also produces three events: a threshold event that follows the fill count, a one-cycle pulse when the queue runs dry, and a one-cycle pulse when a write is refused.

A transmit-enable input gates the drain side. While it is low, bytes pile up and nothing is offered to the serializer. A clear input empties the queue in one cycle. The fill count is reported in a 5-bit field. The depth is 32 by default, so a completely full queue reads 0 in that field, and software has to use the full flag to tell full from empty.

Top module: `uart_txq`

## Requirements
- R1: After reset the level field is 0, `empty` is 1, `full` is 0, `out_valid` is 0, and `wm_evt`, `empty_evt` and `ovf_evt` are all 0.
- R2: Accepted bytes leave on `out_data` in the order they were written. A byte is removed on a cycle where `out_valid` and `out_ready` are both 1.
- R3: `out_valid` is 1 only while `tx_en` is 1 and the queue is not empty. While `tx_en` is 0 the level never decreases, except through a clear.
- R4: `full` is 1 exactly when the level equals DEPTH (32), and it drops in the cycle after the level falls below DEPTH.
- R5: A write while `full` is 1 is discarded, even if a byte leaves in the same cycle. The level and the queued bytes are unchanged, and `ovf_evt` is 1 for exactly the following cycle.
- R6: `empty` is 1 exactly when the level is 0. An accepted write clears it, and it returns to 1 when the level reaches 0.
- R7: After a cycle with an accepted write, `wm_evt` is 1 if the new level is at or above `wm_thresh`.
- R8: `wm_evt` goes to 0 after a cycle in which a byte is removed with no accepted write and the new level is below `wm_thresh`. It also goes to 0 whenever the level becomes 0. Otherwise it holds its value.
- R9: `empty_evt` is 1 for one cycle, in the cycle after the level changes from non-zero to zero, whether by draining or by a clear.
- R10: `fifo_clr` makes the level 0 on the next cycle. A write in the same cycle is dropped without raising `ovf_evt`, and no byte is removed in that cycle.
- R11: `level` equals the fill count modulo 32 (its low 5 bits), so a level of 32 reads 0.
- R12: A cycle with both an accepted write and a removed byte leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to enqueue |
| tx_en | input | 1 | Allows draining toward the serializer |
| fifo_clr | input | 1 | Empties the queue |
| wm_thresh | input | 5 | Threshold for the level event |
| out_valid | output | 1 | Head byte is offered |
| out_data | output | 8 | Head byte |
| out_ready | input | 1 | Serializer takes the head byte |
| full | output | 1 | Level equals DEPTH |
| empty | output | 1 | Level is zero |
| level | output | 5 | Fill count, low 5 bits |
| wm_evt | output | 1 | Threshold event |
| empty_evt | output | 1 | Ran-dry pulse |
| ovf_evt | output | 1 | Refused-write pulse |

## Verification
On every cycle, the assertions check the following:
- a refused write leaves the level alone;
- a clear lands in one cycle;
- a combined push and pop keeps the count;
- the level never exceeds DEPTH;
- the dry pulse never repeats back to back;
- the threshold event is low whenever the queue is empty;
- the level cannot fall while transmit is disabled.

Byte ordering through pointer wrap can only be shown by the bench's scenarios, which compare every drained byte against a queue model. The same holds for the exact cycle in which the threshold event sets and clears for a given threshold, and for the 32-reads-0 aliasing of the level field.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
    localparam int TXQ_DATA_W = 8;

    typedef logic [TXQ_DATA_W-1:0] txq_byte_t;

    typedef struct packed {
        logic wm;
        logic empty_evt;
        logic ovf;
    } txq_evt_t;
endpackage

// File: rtl/txq_mem.sv
module txq_mem #(
    parameter int DEPTH = 32,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [PTR_W-1:0]       waddr,
    input  uart_txq_pkg::txq_byte_t wdata,
    input  logic [PTR_W-1:0]       raddr,
    output uart_txq_pkg::txq_byte_t rdata
);
    uart_txq_pkg::txq_byte_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
    parameter int DEPTH = 32,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             clr,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [LVL_W-1:0] lvl_q,
    output logic [LVL_W-1:0] lvl_d,
    output logic             full_q,
    output logic             empty_q
);
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] lvl;
        logic             full;
        logic             empty;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic [PTR_W-1:0] wr_inc, rd_inc;

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            assign wr_inc = st_q.wr + 1'b1;
            assign rd_inc = st_q.rd + 1'b1;
        end else begin : g_wrap
            assign wr_inc = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
            assign rd_inc = (st_q.rd == PTR_W'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
    endgenerate

    always_comb begin
        push_ok = push_req && !st_q.full && !clr;
        pop_ok  = pop_req && !st_q.empty && !clr;
        st_d    = st_q;
        if (clr) begin
            st_d.wr  = '0;
            st_d.rd  = '0;
            st_d.lvl = '0;
        end else begin
            if (push_ok) st_d.wr = wr_inc;
            if (pop_ok)  st_d.rd = rd_inc;
            case ({push_ok, pop_ok})
                2'b10:   st_d.lvl = st_q.lvl + 1'b1;
                2'b01:   st_d.lvl = st_q.lvl - 1'b1;
                default: st_d.lvl = st_q.lvl;
            endcase
        end
        st_d.full  = (st_d.lvl == DEPTH_L);
        st_d.empty = (st_d.lvl == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wr: '0, rd: '0, lvl: '0, full: 1'b0, empty: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr  = st_q.wr;
    assign rd_ptr  = st_q.rd;
    assign lvl_q   = st_q.lvl;
    assign lvl_d   = st_d.lvl;
    assign full_q  = st_q.full;
    assign empty_q = st_q.empty;

    // R5: a refused write does not move the level
    a_r5_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full_q && !pop_req && !clr) |=> (lvl_q == $past(lvl_q)));
    // R10: clear lands in one cycle
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (lvl_q == '0 && empty_q));
    // R12: push and pop together keep the count
    a_r12_pushpop: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> (lvl_q == $past(lvl_q)));
    // R4: the level never exceeds the depth
    a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q <= DEPTH_L);
endmodule

// File: rtl/txq_events.sv
module txq_events #(
    parameter int LVL_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   push_ok,
    input  logic                   pop_ok,
    input  logic                   drop,
    input  logic [LVL_W-1:0]       lvl_q,
    input  logic [LVL_W-1:0]       lvl_d,
    input  logic [LVL_W-1:0]       thresh,
    output uart_txq_pkg::txq_evt_t evt_q
);
    uart_txq_pkg::txq_evt_t evt_d;

    always_comb begin
        evt_d = evt_q;
        if (lvl_d == '0) begin
            evt_d.wm = 1'b0;
        end else if (push_ok && (lvl_d >= thresh)) begin
            evt_d.wm = 1'b1;
        end else if (pop_ok && !push_ok && (lvl_d < thresh)) begin
            evt_d.wm = 1'b0;
        end
        evt_d.empty_evt = (lvl_q != '0) && (lvl_d == '0);
        evt_d.ovf       = drop && !clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    // R9: the dry pulse never lasts two cycles
    a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q.empty_evt |=> !evt_q.empty_evt);
    // R8: the threshold event is low whenever the queue is empty
    a_r8_wm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == '0) |-> !evt_q.wm);
endmodule

// File: rtl/uart_txq.sv
module uart_txq #(
    parameter int DEPTH   = 32,
    parameter int FIELD_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               tx_en,
    input  logic               fifo_clr,
    input  logic [FIELD_W-1:0] wm_thresh,
    output logic               out_valid,
    output logic [7:0]         out_data,
    input  logic               out_ready,
    output logic               full,
    output logic               empty,
    output logic [FIELD_W-1:0] level,
    output logic               wm_evt,
    output logic               empty_evt,
    output logic               ovf_evt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             push_ok, pop_ok, pop_req, drop;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] lvl_q, lvl_d, thr_ext;
    uart_txq_pkg::txq_evt_t evt_q;

    assign out_valid = tx_en && !empty;
    assign pop_req   = out_valid && out_ready;
    assign drop      = wr_en && full;
    assign thr_ext   = LVL_W'(wm_thresh);
    assign level     = FIELD_W'(lvl_q);

    txq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_req(wr_en), .pop_req(pop_req),
        .clr(fifo_clr), .push_ok(push_ok), .pop_ok(pop_ok),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .lvl_q(lvl_q), .lvl_d(lvl_d),
        .full_q(full), .empty_q(empty)
    );

    txq_mem #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
        .clk(clk), .we(push_ok), .waddr(wr_ptr), .wdata(wr_data),
        .raddr(rd_ptr), .rdata(out_data)
    );

    txq_events #(.LVL_W(LVL_W)) u_evt (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push_ok(push_ok),
        .pop_ok(pop_ok), .drop(drop), .lvl_q(lvl_q), .lvl_d(lvl_d),
        .thresh(thr_ext), .evt_q(evt_q)
    );

    assign wm_evt    = evt_q.wm;
    assign empty_evt = evt_q.empty_evt;
    assign ovf_evt   = evt_q.ovf;

    // R3: with transmit disabled the level cannot fall
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !fifo_clr) |=> (lvl_q >= $past(lvl_q)));
    // R5: the refused-write pulse follows a full queue
    a_r5_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |-> $past(full));
endmodule

// File: tb/sim_uart_txq.sv
`timescale 1ns/1ps
module sim_uart_txq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_en = 1'b0;
    logic       fifo_clr = 1'b0;
    logic [4:0] wm_thresh = 5'd0;
    logic       out_ready = 1'b0;
    logic       out_valid, full, empty, wm_evt, empty_evt, ovf_evt;
    logic [7:0] out_data;
    logic [4:0] level;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    byte unsigned q[$];
    bit exp_wm = 0, exp_ee = 0, exp_ovf = 0;
    bit last_pp = 0, last_clr = 0;
    byte unsigned seed = 8'h3a;

    always #2 clk = ~clk;

    uart_txq u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_en(tx_en), .fifo_clr(fifo_clr), .wm_thresh(wm_thresh),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .full(full), .empty(empty), .level(level), .wm_evt(wm_evt),
        .empty_evt(empty_evt), .ovf_evt(ovf_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: 1 ns after the falling edge, inputs of the coming edge are settled
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            int n_old, n_new;
            bit pop, push, drop;
            string lt;
            lt = last_clr ? "R10 level" : (last_pp ? "R12 level" : "R11 level");
            n_old = q.size();
            chk(level == 5'(n_old), lt, level, n_old % 32);
            chk(full == (n_old == 32), "R4 full", full, n_old == 32);
            chk(empty == (n_old == 0), "R6 empty", empty, n_old == 0);
            chk(out_valid == (tx_en && n_old > 0), "R3 out_valid", out_valid, tx_en && n_old > 0);
            if (out_valid && n_old > 0)
                chk(out_data == q[0], "R2 order", out_data, q[0]);
            chk(wm_evt == exp_wm, exp_wm ? "R7 wm" : "R8 wm", wm_evt, exp_wm);
            chk(empty_evt == exp_ee, "R9 empty_evt", empty_evt, exp_ee);
            chk(ovf_evt == exp_ovf, "R5 ovf_evt", ovf_evt, exp_ovf);
            // model the coming edge
            pop  = !fifo_clr && tx_en && out_ready && n_old > 0;
            push = !fifo_clr && wr_en && n_old < 32;
            drop = !fifo_clr && wr_en && n_old == 32;
            if (fifo_clr) q.delete();
            if (pop)  void'(q.pop_front());
            if (push) q.push_back(wr_data);
            n_new = q.size();
            exp_ovf = drop;
            exp_ee  = (n_old > 0) && (n_new == 0);
            if (n_new == 0) exp_wm = 0;
            else if (push && n_new >= wm_thresh) exp_wm = 1;
            else if (pop && !push && n_new < wm_thresh) exp_wm = 0;
            last_pp  = push && pop;
            last_clr = fifo_clr;
        end
    end

    task automatic cyc(input bit we, input bit en, input bit rdy, input bit clr);
        @(negedge clk);
        seed = seed * 8'd13 + 8'd7;
        wr_en = we; wr_data = seed; tx_en = en; out_ready = rdy; fifo_clr = clr;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(level == 0, "R1 level", level, 0);
        chk(empty == 1, "R1 empty", empty, 1);
        chk(full == 0, "R1 full", full, 0);
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk({wm_evt, empty_evt, ovf_evt} == 3'b000, "R1 events", {wm_evt, empty_evt, ovf_evt}, 0);
        // R3/R7: fill with transmit disabled, threshold 4
        wm_thresh = 5'd4;
        for (int i = 0; i < 6; i++) cyc(1, 0, 1, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);
        // R2/R8/R9: drain with a stalling serializer
        for (int i = 0; i < 14; i++) cyc(0, 1, i[0], 0);
        // R4/R5/R11: fill to depth, then refused writes (one while draining)
        wm_thresh = 5'd16;
        for (int i = 0; i < 32; i++) cyc(1, 0, 0, 0);
        cyc(1, 0, 0, 0);
        cyc(1, 1, 1, 0);
        cyc(0, 0, 0, 0);
        // R12: steady push and pop
        for (int i = 0; i < 10; i++) cyc(1, 1, 1, 0);
        for (int i = 0; i < 40; i++) cyc(0, 1, 1, 0);
        // R10: clear with a concurrent write
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
        cyc(1, 1, 1, 1);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        // threshold 0 and a single byte
        wm_thresh = 5'd0;
        cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0);
        // wrap-around ordering with random stalls
        wm_thresh = 5'd9;
        for (int i = 0; i < 120; i++) cyc(seed[0] | seed[3], 1, seed[2], 0);
        for (int i = 0; i < 40; i++) cyc(0, 1, 1, 0);
        @(negedge clk); #2;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule